// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the working registers of a small 8-bit CPU core. Thirty-two byte cells are arranged as four banks of eight registers. Two bits of the status word choose which bank the register ports see. The byte port names a register by its position in the bank. The pair port names one of four 16-bit register pairs. The same thirty-two cells are also reachable through a byte-wide port in the data address space. This lets software that uses plain loads and stores inspect or change any bank, including banks that are not currently selected.

Besides the register cells, the block keeps the status word, a 16-bit stack pointer whose lowest bit is always even, and three 8-bit segment registers: code, extra and mirror. A purely combinational evaluator answers branch conditions from the zero and carry flags, or from a supplied operand. Reads on every port are combinational. Every write takes effect at the next rising clock edge.

Top module: `regbank_core`

## Requirements
- R1: The memory port reaches cell k (k = 0..31) at address 0xFFEE0 + k. This is the same storage the register ports use. `mm_hit` is high only inside that range. Outside the range `mm_rdata` is 0x00 and a write changes nothing.
- R2: The bank number is {psw[5], psw[3]}. The active bank occupies cells (3 − bank)·8 to (3 − bank)·8 + 7, so bank 0 is the top eight cells.
- R3: The byte selector values 0 to 7 address X, A, C, B, E, D, L and H, which are bank offsets 0 to 7.
- R4: The pair selector values 0, 1, 2 and 3 address AX, BC, DE and HL. The high byte is A, B, D or H (odd offset) and the low byte is X, C, E or L (even offset). A pair write splits its value the same way.
- R5: After reset, every cell reads 0x11, the status word reads 0x06, the extra segment reads 0x0F, and the code segment, the mirror segment and the stack pointer read 0x00.
- R6: A stack pointer write stores the written value with bit 0 cleared.
- R7: The condition codes are 0 T (operand ≠ 0), 1 F (operand = 0), 2 C (CY = psw[0]), 3 NC, 4 Z (Z = psw[6]), 5 NZ, 6 H (neither Z nor CY) and 7 NH (Z or CY).
- R8: Codes 8 to 15 raise `cond_err` and force `cond_true` low. Valid codes keep `cond_err` low.
- R9: A status word write is registered. Register-port reads and writes in the same cycle still use the old bank, and the new bank applies from the next cycle.
- R10: When ports write the same cell in one cycle, the pair port beats the byte port, and the byte port beats the memory port.
- R11: Segment selector 0 writes the code segment, 1 the extra segment, 2 the mirror segment, and 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_we | input | 1 | Byte port write enable |
| rb_sel | input | 3 | Byte register selector |
| rb_wdata | input | 8 | Byte port write data |
| rb_rdata | output | 8 | Byte port read data |
| rp_we | input | 1 | Pair port write enable |
| rp_sel | input | 2 | Pair selector |
| rp_wdata | input | 16 | Pair port write data |
| rp_rdata | output | 16 | Pair port read data |
| mm_we | input | 1 | Memory port write enable |
| mm_addr | input | 20 | Memory port byte address |
| mm_wdata | input | 8 | Memory port write data |
| mm_rdata | output | 8 | Memory port read data |
| mm_hit | output | 1 | Address falls in the register window |
| psw_we | input | 1 | Status word write enable |
| psw_wdata | input | 8 | Status word write data |
| psw_q | output | 8 | Status word |
| sp_we | input | 1 | Stack pointer write enable |
| sp_wdata | input | 16 | Stack pointer write data |
| sp_q | output | 16 | Stack pointer |
| seg_we | input | 1 | Segment write enable |
| seg_sel | input | 2 | Segment selector |
| seg_wdata | input | 8 | Segment write data |
| cs_q | output | 8 | Code segment |
| es_q | output | 8 | Extra segment |
| pmc_q | output | 8 | Mirror segment |
| cond_code | input | 4 | Condition code |
| cond_operand | input | 16 | Operand for T and F |
| cond_true | output | 1 | Condition result |
| cond_err | output | 1 | Invalid condition code |

## Verification
The clocked properties assume that every input is a known 0 or 1 at each rising edge once reset is released. The bench meets this by driving every input on the falling edge and never leaving one undriven. The properties that check one write port's effect assume that no higher-priority port hits the same cell in that cycle, so those properties carry that condition as a guard. The bench, by contrast, deliberately aims all three write ports at one cell, both in directed cycles and in random ones, where most memory addresses are drawn from inside the window. The status word is rewritten often, so bank switches overlap with register traffic.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int unsigned BANKS   = 4;
    localparam int unsigned REGS    = 8;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned CELLS   = BANKS * REGS;
    localparam int unsigned OFF_W   = $clog2(CELLS);
    localparam int unsigned SEL_W   = $clog2(REGS);
    localparam int unsigned BANK_W  = $clog2(BANKS);
    localparam int unsigned PAIR_W  = $clog2(REGS / 2);
    localparam int unsigned SP_W    = 2 * BYTE_W;

    // status word bit positions
    localparam int unsigned ST_IE   = 7;
    localparam int unsigned ST_Z    = 6;
    localparam int unsigned ST_BK1  = 5;
    localparam int unsigned ST_AC   = 4;
    localparam int unsigned ST_BK0  = 3;
    localparam int unsigned ST_ISP1 = 2;
    localparam int unsigned ST_ISP0 = 1;
    localparam int unsigned ST_CY   = 0;

    localparam logic [BYTE_W-1:0] CELL_INIT = 8'h11;
    localparam logic [BYTE_W-1:0] PSW_INIT  = 8'h06;
    localparam logic [BYTE_W-1:0] ES_INIT   = 8'h0F;
    localparam logic [BYTE_W-1:0] CS_INIT   = 8'h00;
    localparam logic [BYTE_W-1:0] PMC_INIT  = 8'h00;

    typedef enum logic [3:0] {
        CC_TRUE    = 4'd0,
        CC_FALSE   = 4'd1,
        CC_CARRY   = 4'd2,
        CC_NCARRY  = 4'd3,
        CC_ZERO    = 4'd4,
        CC_NZERO   = 4'd5,
        CC_HIGHER  = 4'd6,
        CC_NHIGHER = 4'd7
    } cc_e;

    typedef enum logic [1:0] {
        SEG_CODE   = 2'd0,
        SEG_EXTRA  = 2'd1,
        SEG_MIRROR = 2'd2,
        SEG_NONE   = 2'd3
    } seg_e;

    typedef struct packed {
        logic [CELLS-1:0][BYTE_W-1:0] cells;
    } cell_arr_t;

    typedef struct packed {
        logic [BYTE_W-1:0] psw;
        logic [SP_W-1:0]   sp;
        logic [BYTE_W-1:0] cs;
        logic [BYTE_W-1:0] es;
        logic [BYTE_W-1:0] pmc;
    } ctl_t;
endpackage

// File: rtl/regbank_array.sv
module regbank_array
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank,
    input  logic              b_we,
    input  logic [SEL_W-1:0]  b_sel,
    input  logic [BYTE_W-1:0] b_wdata,
    output logic [BYTE_W-1:0] b_rdata,
    input  logic              p_we,
    input  logic [PAIR_W-1:0] p_sel,
    input  logic [SP_W-1:0]   p_wdata,
    output logic [SP_W-1:0]   p_rdata,
    input  logic              m_we,
    input  logic [OFF_W-1:0]  m_off,
    input  logic [BYTE_W-1:0] m_wdata,
    output logic [BYTE_W-1:0] m_rdata
);
    cell_arr_t arr_d, arr_q;

    logic [BANK_W-1:0] slot;
    logic [OFF_W-1:0]  b_off;
    logic [OFF_W-1:0]  p_lo_off;
    logic [OFF_W-1:0]  p_hi_off;

    // reversed placement: bank n starts at (BANKS-1-n)*REGS
    assign slot     = BANK_W'(BANKS - 1) - bank;
    assign b_off    = {slot, b_sel};
    assign p_lo_off = {slot, p_sel, 1'b0};
    assign p_hi_off = {slot, p_sel, 1'b1};

    always_comb begin
        arr_d = arr_q;
        // lowest priority first, later assignments override
        if (m_we) arr_d.cells[m_off] = m_wdata;
        if (b_we) arr_d.cells[b_off] = b_wdata;
        if (p_we) begin
            arr_d.cells[p_lo_off] = p_wdata[BYTE_W-1:0];
            arr_d.cells[p_hi_off] = p_wdata[SP_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) arr_q.cells[i] <= CELL_INIT;
        end else begin
            arr_q <= arr_d;
        end
    end

    assign b_rdata = arr_q.cells[b_off];
    assign p_rdata = {arr_q.cells[p_hi_off], arr_q.cells[p_lo_off]};
    assign m_rdata = arr_q.cells[m_off];

    logic p_hits_m, p_hits_b;
    assign p_hits_m = p_we && (p_lo_off == m_off || p_hi_off == m_off);
    assign p_hits_b = p_we && (p_lo_off == b_off || p_hi_off == b_off);

    p_pair_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        p_we |=> (arr_q.cells[$past(p_lo_off)] == $past(p_wdata[BYTE_W-1:0]))
              && (arr_q.cells[$past(p_hi_off)] == $past(p_wdata[SP_W-1:BYTE_W])));

    p_byte_over_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (b_we && !p_hits_b) |=> arr_q.cells[$past(b_off)] == $past(b_wdata));

    p_mem_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_we && !(b_we && b_off == m_off) && !p_hits_m)
            |=> arr_q.cells[$past(m_off)] == $past(m_wdata));

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_we && !b_we && !p_we) |=> $stable(arr_q));
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psw_we,
    input  logic [BYTE_W-1:0] psw_wdata,
    input  logic              sp_we,
    input  logic [SP_W-1:0]   sp_wdata,
    input  logic              seg_we,
    input  logic [1:0]        seg_sel,
    input  logic [BYTE_W-1:0] seg_wdata,
    output ctl_t              ctl
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (psw_we) ctl_d.psw = psw_wdata;
        if (sp_we)  ctl_d.sp  = {sp_wdata[SP_W-1:1], 1'b0};
        if (seg_we) begin
            unique case (seg_e'(seg_sel))
                SEG_CODE:   ctl_d.cs  = seg_wdata;
                SEG_EXTRA:  ctl_d.es  = seg_wdata;
                SEG_MIRROR: ctl_d.pmc = seg_wdata;
                SEG_NONE:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.psw <= PSW_INIT;
            ctl_q.sp  <= '0;
            ctl_q.cs  <= CS_INIT;
            ctl_q.es  <= ES_INIT;
            ctl_q.pmc <= PMC_INIT;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;

    p_sp_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |=> ctl_q.sp == {$past(sp_wdata[SP_W-1:1]), 1'b0});

    p_psw_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        psw_we |=> ctl_q.psw == $past(psw_wdata));

    p_seg_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_we && seg_sel == 2'd3) |=> $stable(ctl_q.cs) && $stable(ctl_q.es)
                                      && $stable(ctl_q.pmc));
endmodule

// File: rtl/regbank_cond.sv
module regbank_cond
    import regbank_pkg::*;
(
    input  logic            [3:0] code,
    input  logic                  z_flag,
    input  logic                  cy_flag,
    input  logic [SP_W-1:0]       operand,
    output logic                  taken,
    output logic                  err
);
    always_comb begin
        taken = 1'b0;
        err   = 1'b0;
        case (cc_e'(code))
            CC_TRUE:    taken = |operand;
            CC_FALSE:   taken = ~|operand;
            CC_CARRY:   taken = cy_flag;
            CC_NCARRY:  taken = ~cy_flag;
            CC_ZERO:    taken = z_flag;
            CC_NZERO:   taken = ~z_flag;
            CC_HIGHER:  taken = ~(z_flag | cy_flag);
            CC_NHIGHER: taken = z_flag | cy_flag;
            default:    err   = 1'b1;
        endcase
    end

    always_comb begin
        if (err) begin
            p_err_false_r8: assert (!taken);
        end
    end
endmodule

// File: rtl/regbank_core.sv
module regbank_core
    import regbank_pkg::*;
#(
    parameter int unsigned          ADDR_W   = 20,
    parameter logic [ADDR_W-1:0]    WIN_BASE = 20'hFFEE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rb_we,
    input  logic [2:0]        rb_sel,
    input  logic [7:0]        rb_wdata,
    output logic [7:0]        rb_rdata,
    input  logic              rp_we,
    input  logic [1:0]        rp_sel,
    input  logic [15:0]       rp_wdata,
    output logic [15:0]       rp_rdata,
    input  logic              mm_we,
    input  logic [ADDR_W-1:0] mm_addr,
    input  logic [7:0]        mm_wdata,
    output logic [7:0]        mm_rdata,
    output logic              mm_hit,
    input  logic              psw_we,
    input  logic [7:0]        psw_wdata,
    output logic [7:0]        psw_q,
    input  logic              sp_we,
    input  logic [15:0]       sp_wdata,
    output logic [15:0]       sp_q,
    input  logic              seg_we,
    input  logic [1:0]        seg_sel,
    input  logic [7:0]        seg_wdata,
    output logic [7:0]        cs_q,
    output logic [7:0]        es_q,
    output logic [7:0]        pmc_q,
    input  logic [3:0]        cond_code,
    input  logic [15:0]       cond_operand,
    output logic              cond_true,
    output logic              cond_err
);
    localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + ADDR_W'(CELLS - 1);

    ctl_t              ctl;
    logic [BANK_W-1:0] bank;
    logic [OFF_W-1:0]  win_off;
    logic [ADDR_W-1:0] win_rel;
    logic [BYTE_W-1:0] arr_m_rdata;

    assign bank    = {ctl.psw[ST_BK1], ctl.psw[ST_BK0]};
    assign mm_hit  = (mm_addr >= WIN_BASE) && (mm_addr <= WIN_LAST);
    assign win_rel = mm_addr - WIN_BASE;
    assign win_off = win_rel[OFF_W-1:0];

    regbank_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .psw_we    (psw_we),
        .psw_wdata (psw_wdata),
        .sp_we     (sp_we),
        .sp_wdata  (sp_wdata),
        .seg_we    (seg_we),
        .seg_sel   (seg_sel),
        .seg_wdata (seg_wdata),
        .ctl       (ctl)
    );

    regbank_array u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank    (bank),
        .b_we    (rb_we),
        .b_sel   (rb_sel),
        .b_wdata (rb_wdata),
        .b_rdata (rb_rdata),
        .p_we    (rp_we),
        .p_sel   (rp_sel),
        .p_wdata (rp_wdata),
        .p_rdata (rp_rdata),
        .m_we    (mm_we && mm_hit),
        .m_off   (win_off),
        .m_wdata (mm_wdata),
        .m_rdata (arr_m_rdata)
    );

    regbank_cond u_cond (
        .code    (cond_code),
        .z_flag  (ctl.psw[ST_Z]),
        .cy_flag (ctl.psw[ST_CY]),
        .operand (cond_operand),
        .taken   (cond_true),
        .err     (cond_err)
    );

    assign mm_rdata = mm_hit ? arr_m_rdata : '0;
    assign psw_q    = ctl.psw;
    assign sp_q     = ctl.sp;
    assign cs_q     = ctl.cs;
    assign es_q     = ctl.es;
    assign pmc_q    = ctl.pmc;

    p_miss_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mm_hit |-> mm_rdata == 8'h00);

    p_bank_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_we && !rb_we && !rp_we && !mm_we) |=> rb_rdata ==
            u_array.arr_q.cells[{BANK_W'(BANKS - 1) - {$past(psw_wdata[ST_BK1]),
                                 $past(psw_wdata[ST_BK0])}, rb_sel}]);
endmodule

// File: tb/tb_regbank_core.sv
`timescale 1ns/1ps
module tb_regbank_core;
    localparam int BASE = 'hFFEE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rb_we = 0;  logic [2:0] rb_sel = 0;  logic [7:0] rb_wdata = 0;
    logic [7:0]  rb_rdata;
    logic        rp_we = 0;  logic [1:0] rp_sel = 0;  logic [15:0] rp_wdata = 0;
    logic [15:0] rp_rdata;
    logic        mm_we = 0;  logic [19:0] mm_addr = 0; logic [7:0] mm_wdata = 0;
    logic [7:0]  mm_rdata;   logic mm_hit;
    logic        psw_we = 0; logic [7:0] psw_wdata = 0; logic [7:0] psw_q;
    logic        sp_we = 0;  logic [15:0] sp_wdata = 0; logic [15:0] sp_q;
    logic        seg_we = 0; logic [1:0] seg_sel = 0; logic [7:0] seg_wdata = 0;
    logic [7:0]  cs_q, es_q, pmc_q;
    logic [3:0]  cond_code = 0; logic [15:0] cond_operand = 0;
    logic        cond_true, cond_err;

    always #2.5 clk = ~clk;

    regbank_core dut (.*);

    int total = 0;
    int bad = 0;

    // reference model
    int m_cell[32];
    int m_psw, m_sp, m_cs, m_es, m_pmc;

    function automatic int cell_of(int sel);
        int bk;
        bk = ((m_psw >> 5) & 1) * 2 + ((m_psw >> 3) & 1);
        return (3 - bk) * 8 + sel;
    endfunction

    function automatic int cond_ref(int code, int opnd, output int err);
        int z, cy;
        z = (m_psw >> 6) & 1; cy = m_psw & 1; err = 0;
        case (code)
            0: return (opnd != 0);
            1: return (opnd == 0);
            2: return cy;
            3: return 1 - cy;
            4: return z;
            5: return 1 - z;
            6: return (z | cy) ? 0 : 1;
            7: return z | cy;
            default: begin err = 1; return 0; end
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int exp_pair, exp_mm, e_err, e_true;
        bit in_win;
        in_win = (int'(mm_addr) >= BASE) && (int'(mm_addr) < BASE + 32);
        chk(rb_rdata == m_cell[cell_of(rb_sel)], "R3/R2 byte read",
            rb_rdata, m_cell[cell_of(rb_sel)]);
        exp_pair = m_cell[cell_of(rp_sel * 2 + 1)] * 256 + m_cell[cell_of(rp_sel * 2)];
        chk(rp_rdata == exp_pair, "R4 pair read", rp_rdata, exp_pair);
        exp_mm = in_win ? m_cell[int'(mm_addr) - BASE] : 0;
        chk(mm_rdata == exp_mm && mm_hit == in_win, "R1 window read", mm_rdata, exp_mm);
        chk(psw_q == m_psw, "R9 status word", psw_q, m_psw);
        chk(sp_q == m_sp, "R6 stack pointer", sp_q, m_sp);
        chk(cs_q == m_cs && es_q == m_es && pmc_q == m_pmc, "R11 segments",
            {cs_q, es_q, pmc_q}, m_cs * 65536 + m_es * 256 + m_pmc);
        e_true = cond_ref(cond_code, cond_operand, e_err);
        chk(cond_true == e_true[0], "R7 condition", cond_true, e_true);
        chk(cond_err == e_err[0], "R8 condition error", cond_err, e_err);
    endtask

    // one cycle: inputs already set after a falling edge
    task automatic step();
        #1 compare();
        @(posedge clk);
        #0.1;
        if (mm_we && int'(mm_addr) >= BASE && int'(mm_addr) < BASE + 32)
            m_cell[int'(mm_addr) - BASE] = mm_wdata;
        if (rb_we) m_cell[cell_of(rb_sel)] = rb_wdata;
        if (rp_we) begin
            m_cell[cell_of(rp_sel * 2)]     = rp_wdata[7:0];
            m_cell[cell_of(rp_sel * 2 + 1)] = rp_wdata[15:8];
        end
        if (psw_we) m_psw = psw_wdata;
        if (sp_we)  m_sp  = sp_wdata & 16'hFFFE;
        if (seg_we) begin
            if (seg_sel == 0) m_cs = seg_wdata;
            if (seg_sel == 1) m_es = seg_wdata;
            if (seg_sel == 2) m_pmc = seg_wdata;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        rb_we = 0; rp_we = 0; mm_we = 0; psw_we = 0; sp_we = 0; seg_we = 0;
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_cell[i] = 'h11;
        m_psw = 'h06; m_sp = 0; m_cs = 0; m_es = 'h0F; m_pmc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5: reset values, scan every cell through the window
        for (int k = 0; k < 32; k++) begin
            mm_addr = 20'(BASE + k); rb_sel = 3'(k % 8);
            #1 chk(mm_rdata == 8'h11, "R5 reset cell", mm_rdata, 'h11);
            @(negedge clk);
        end
        chk(psw_q == 8'h06 && es_q == 8'h0F && cs_q == 0 && pmc_q == 0 && sp_q == 0,
            "R5 reset control", {psw_q, es_q, cs_q, pmc_q}, 'h060F0000);

        // R3: write each byte name in bank 0, read through window top cells
        for (int s = 0; s < 8; s++) begin
            quiet(); rb_we = 1; rb_sel = 3'(s); rb_wdata = 8'(8'hA0 + s);
            mm_addr = 20'(BASE + 24 + s); step();
        end
        quiet(); mm_addr = 20'(BASE + 25); #1
        chk(mm_rdata == 8'hA1, "R3 A at offset 1 of bank 0", mm_rdata, 'hA1);
        step();

        // R9/R2: switch to bank 2 while writing; write still lands in bank 0
        quiet(); psw_we = 1; psw_wdata = 8'h20; rb_we = 1; rb_sel = 3'd7; rb_wdata = 8'h5C;
        step();
        quiet(); mm_addr = 20'(BASE + 31); #1
        chk(mm_rdata == 8'h5C, "R9 old bank on switch cycle", mm_rdata, 'h5C);
        step();
        quiet(); rp_we = 1; rp_sel = 2'd3; rp_wdata = 16'hBEEF; step();
        quiet(); mm_addr = 20'(BASE + 15); #1
        chk(mm_rdata == 8'hBE, "R2 bank 2 at cells 8..15, R4 high byte", mm_rdata, 'hBE);
        step();

        // R10: all three ports on one cell
        quiet(); mm_we = 1; mm_addr = 20'(BASE + 8); mm_wdata = 8'h33;
        rb_we = 1; rb_sel = 0; rb_wdata = 8'h44;
        rp_we = 1; rp_sel = 0; rp_wdata = 16'h6655; step();
        quiet(); mm_addr = 20'(BASE + 8); #1
        chk(mm_rdata == 8'h55, "R10 pair wins", mm_rdata, 'h55);
        step();
        quiet(); mm_we = 1; mm_addr = 20'(BASE + 9); mm_wdata = 8'h77;
        rb_we = 1; rb_sel = 1; rb_wdata = 8'h88; step();
        quiet(); mm_addr = 20'(BASE + 9); #1
        chk(mm_rdata == 8'h88, "R10 byte beats memory", mm_rdata, 'h88);
        step();

        // R1: writes just outside the window change nothing
        quiet(); mm_we = 1; mm_addr = 20'(BASE - 1); mm_wdata = 8'hEE; step();
        quiet(); mm_we = 1; mm_addr = 20'(BASE + 32); mm_wdata = 8'hEE; step();
        quiet(); mm_addr = 20'(BASE + 32); step();

        // R6: odd stack pointer; R11: selector 3 ignored
        quiet(); sp_we = 1; sp_wdata = 16'h1235; seg_we = 1; seg_sel = 3; seg_wdata = 8'h99;
        step();
        quiet(); #1
        chk(sp_q == 16'h1234, "R6 bit 0 cleared", sp_q, 'h1234);
        chk(es_q == 8'h0F && cs_q == 0 && pmc_q == 0, "R11 selector 3 ignored",
            {cs_q, es_q, pmc_q}, 'h000F00);
        step();

        // R7/R8: every code with several flag settings
        for (int f = 0; f < 4; f++) begin
            quiet(); psw_we = 1; psw_wdata = 8'(((f >> 1) << 6) | (f & 1)); step();
            quiet();
            for (int c = 0; c < 16; c++) begin
                cond_code = 4'(c); cond_operand = (c % 2) ? 16'h0000 : 16'h0100;
                step();
            end
        end

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            rb_we = ($urandom % 3) == 0; rb_sel = 3'($urandom); rb_wdata = 8'($urandom);
            rp_we = ($urandom % 4) == 0; rp_sel = 2'($urandom); rp_wdata = 16'($urandom);
            mm_we = ($urandom % 2) == 0; mm_wdata = 8'($urandom);
            if (($urandom % 4) != 0) mm_addr = 20'(BASE + ($urandom % 32));
            else mm_addr = 20'(BASE - 4 + ($urandom % 40));
            psw_we = ($urandom % 6) == 0; psw_wdata = 8'($urandom);
            sp_we = ($urandom % 5) == 0; sp_wdata = 16'($urandom);
            seg_we = ($urandom % 5) == 0; seg_sel = 2'($urandom); seg_wdata = 8'($urandom);
            cond_code = 4'($urandom);
            cond_operand = (($urandom % 3) == 0) ? 16'h0 : 16'($urandom);
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule